// File: doc/BRIEF.md
# Pipelined-to-Classic Wishbone Bridge

This bridge connects a Wishbone master that issues pipelined accesses to a classic Wishbone slave. The classic slave has no stall output and decodes word addresses. A pipelined master would normally raise its strobe for a single cycle and then move on. A classic slave needs the strobe held until it answers. The bridge closes that gap by driving the pipelined stall signal high while a cycle is open and the slave has not yet answered. A compliant master therefore keeps its request on the bus, and only one access is outstanding at a time.

The datapath has no registers. The master's byte address loses its low lane-select bits to become the slave's word address. Write data, byte selects and write enable go straight through to the slave. Read data, ACK and ERR come back to the master in the same cycle the slave returns them. Either ACK or ERR ends the access and drops stall. Parameters set the data width and the byte-address width, and the word-address width follows from them.

Top module: `wb_pipe_to_classic`

## Requirements
- R1: The slave word address equals the master byte address shifted right by log2(DATA_W/8), which is 2 for 32 bits. A 28-bit byte address maps to a 26-bit word address. Master accesses are word aligned.
- R2: While the master cycle line is low, stall toward the master is 0.
- R3: While the master cycle line is high and the slave returns neither ACK nor ERR, stall toward the master is 1.
- R4: In a cycle where the slave returns ERR, stall is 0 and the master sees ERR and no ACK. The access ends the same way ACK ends it.
- R5: The strobe to the slave equals master cycle AND master strobe. Once asserted, it stays high every cycle until the slave returns ACK or ERR, whatever the slave's latency.
- R6: Write enable, write data and byte selects reach the slave unchanged in the same cycle.
- R7: Read data, ACK and ERR from the slave appear at the master in the same cycle, with no register between.
- R8: A slave that answers in the cycle the strobe rises completes the access in one cycle with no stall. A slave with latency N holds the master for N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | BADDR_W | Master byte address |
| m_dat_w | input | DATA_W | Master write data |
| m_sel | input | DATA_W/8 | Master byte selects |
| m_stall | output | 1 | Stall toward master |
| m_ack | output | 1 | Acknowledge toward master |
| m_err | output | 1 | Error toward master |
| m_dat_r | output | DATA_W | Read data toward master |
| s_cyc | output | 1 | Slave cycle |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_adr | output | BADDR_W-log2(DATA_W/8) | Slave word address |
| s_dat_w | output | DATA_W | Slave write data |
| s_sel | output | DATA_W/8 | Slave byte selects |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error |
| s_dat_r | input | DATA_W | Slave read data |

## Verification
Request start and completion can fall in the same cycle. This happens when a zero-latency slave answers in the very cycle the strobe first rises. Stall must then be low at once, and a stall wired to 0 or held one cycle too long would look alike in the other tests. The bench provokes this case with zero-latency reads, writes and errors, placed next to accesses of latency one to four. Every clock it compares stall, strobe and the returned handshake against a behavioural model of the slave. It also measures each access's cycle count against latency plus one.

// File: rtl/wb_pipe_to_classic.sv
module wb_pipe_to_classic #(
  parameter int DATA_W  = 32,
  parameter int BADDR_W = 28
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   m_cyc,
  input  logic                                   m_stb,
  input  logic                                   m_we,
  input  logic [BADDR_W-1:0]                     m_adr,
  input  logic [DATA_W-1:0]                      m_dat_w,
  input  logic [DATA_W/8-1:0]                    m_sel,
  output logic                                   m_stall,
  output logic                                   m_ack,
  output logic                                   m_err,
  output logic [DATA_W-1:0]                      m_dat_r,
  output logic                                   s_cyc,
  output logic                                   s_stb,
  output logic                                   s_we,
  output logic [BADDR_W-$clog2(DATA_W/8)-1:0]    s_adr,
  output logic [DATA_W-1:0]                      s_dat_w,
  output logic [DATA_W/8-1:0]                    s_sel,
  input  logic                                   s_ack,
  input  logic                                   s_err,
  input  logic [DATA_W-1:0]                      s_dat_r
);
  localparam int SEL_W = DATA_W / 8;
  localparam int SHIFT = $clog2(SEL_W);

  logic done;

  assign done    = s_ack | s_err;

  assign s_cyc   = m_cyc;
  assign s_stb   = m_cyc & m_stb;
  assign s_we    = m_we;
  assign s_adr   = m_adr[BADDR_W-1:SHIFT];
  assign s_dat_w = m_dat_w;
  assign s_sel   = m_sel;

  assign m_stall = m_cyc & ~done;
  assign m_ack   = s_ack;
  assign m_err   = s_err;
  assign m_dat_r = s_dat_r;

  // R1
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (m_cyc && m_stb) |-> (m_adr[SHIFT-1:0] == '0));

  // R2
  idle_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    !m_cyc |-> !m_stall);

  // R3
  wait_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (s_stb && !s_ack && !s_err) |-> m_stall);

  // R4
  end_release_chk: assert property (@(posedge clk) disable iff (rst)
    (s_cyc && (s_ack || s_err)) |-> !m_stall);

  // R5
  stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_stb && !s_ack && !s_err) |=> s_stb);

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (s_stb && m_stall) |=> ($stable(s_adr) && $stable(s_we) && $stable(s_sel)));
endmodule

// File: tb/sim_wb_pipe_to_classic.sv
`timescale 1ns/1ps
module sim_wb_pipe_to_classic;
  localparam int DW = 32;
  localparam int BW = 28;
  localparam int WW = 26;

  logic clk = 0;
  logic rst = 1;
  logic m_cyc = 0, m_stb = 0, m_we = 0;
  logic [BW-1:0] m_adr = '0;
  logic [DW-1:0] m_dat_w = '0;
  logic [3:0] m_sel = '0;
  logic m_stall, m_ack, m_err;
  logic [DW-1:0] m_dat_r;
  logic s_cyc, s_stb, s_we;
  logic [WW-1:0] s_adr;
  logic [DW-1:0] s_dat_w;
  logic [3:0] s_sel;
  logic s_ack, s_err;
  logic [DW-1:0] s_dat_r;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  logic want_err = 0;
  int wait_cnt = 0;
  logic pend = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wb_pipe_to_classic #(.DATA_W(DW), .BADDR_W(BW)) u0 (
    .clk(clk), .rst(rst),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr),
    .m_dat_w(m_dat_w), .m_sel(m_sel), .m_stall(m_stall), .m_ack(m_ack),
    .m_err(m_err), .m_dat_r(m_dat_r),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_w(s_dat_w), .s_sel(s_sel), .s_ack(s_ack), .s_err(s_err),
    .s_dat_r(s_dat_r)
  );

  function automatic logic [DW-1:0] rd_of(input logic [WW-1:0] w);
    return {w, 6'h15} ^ 32'hA5A5_0000;
  endfunction

  // behavioural slave: answers after lat waiting cycles
  assign s_ack   = s_cyc && s_stb && (wait_cnt == lat) && !want_err;
  assign s_err   = s_cyc && s_stb && (wait_cnt == lat) && want_err;
  assign s_dat_r = rd_of(s_adr);

  always @(posedge clk) begin
    if (rst) wait_cnt <= 0;
    else if (s_stb && !(s_ack || s_err)) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (!rst) begin
      logic exp_stall;
      exp_stall = m_cyc ? !(s_ack || s_err) : 1'b0;
      if (!m_cyc) chk(m_stall == 1'b0, "R2 stall idle", m_stall, 0);
      else if (s_err) chk(m_stall == exp_stall, "R4 stall on err", m_stall, exp_stall);
      else chk(m_stall == exp_stall, "R3 stall open cycle", m_stall, exp_stall);
      chk(s_stb == (m_cyc && m_stb), "R5 strobe pass", s_stb, m_cyc && m_stb);
      if (pend) chk(s_stb == 1'b1, "R5 strobe held", s_stb, 1);
      pend = s_stb && !(s_ack || s_err);
      if (m_cyc && m_stb) begin
        chk(s_adr == m_adr[BW-1:2], "R1 word address", s_adr, m_adr[BW-1:2]);
        chk(s_we == m_we && s_sel == m_sel && s_dat_w == m_dat_w, "R6 request fields",
            {s_we, s_sel, s_dat_w}, {m_we, m_sel, m_dat_w});
      end
      chk(m_ack == s_ack && m_err == s_err && m_dat_r == s_dat_r, "R7 response path",
          {m_ack, m_err, m_dat_r}, {s_ack, s_err, s_dat_r});
    end
  end

  task automatic access(input logic [BW-1:0] adr, input logic we, input logic [DW-1:0] dat,
                        input logic [3:0] sel, input int l, input logic e, input logic keep);
    int n;
    logic done;
    n = 0;
    done = 0;
    @(posedge clk); #1;
    m_cyc = 1; m_stb = 1; m_we = we; m_adr = adr; m_dat_w = dat; m_sel = sel;
    lat = l; want_err = e;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
      if (!m_stall) begin
        done = 1;
        chk(m_ack == !e && m_err == e, e ? "R4 err seen" : "R7 ack seen", {m_ack, m_err}, {!e, e});
        if (!we && !e) chk(m_dat_r == rd_of(adr[BW-1:2]), "R7 read data", m_dat_r, rd_of(adr[BW-1:2]));
      end else begin
        @(posedge clk); #1;
      end
    end
    chk(n == l + 1, "R8 access length", n, l + 1);
    @(posedge clk); #1;
    m_stb = 0;
    if (!keep) m_cyc = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(m_stall == 0 && s_stb == 0 && s_cyc == 0, "R2 reset idle", {m_stall, s_stb, s_cyc}, 0);

    access(28'h0000000, 1, 32'h1111_2222, 4'hF, 0, 0, 0);
    access(28'h0000004, 0, 32'h0, 4'hF, 0, 0, 0);
    access(28'h0123458, 1, 32'hDEAD_BEEF, 4'h3, 1, 0, 0);
    access(28'h0123458, 0, 32'h0, 4'hC, 2, 0, 0);
    access(28'hFFFFFFC, 0, 32'h0, 4'hF, 4, 0, 0);
    access(28'hFFFFFFC, 1, 32'hCAFE_F00D, 4'h1, 3, 0, 0);
    access(28'h0800000, 0, 32'h0, 4'hF, 0, 1, 0);
    access(28'h0800010, 1, 32'h5555_AAAA, 4'h8, 3, 1, 0);
    // cycle held open across back-to-back accesses
    access(28'h0000100, 1, 32'h0000_0001, 4'hF, 2, 0, 1);
    @(negedge clk);
    chk(m_stall == 1, "R3 open cycle no strobe", m_stall, 1);
    access(28'h0000104, 0, 32'h0, 4'hF, 0, 0, 1);
    access(28'h0000108, 0, 32'h0, 4'hF, 1, 1, 0);
    for (int i = 0; i < 20; i++)
      access({i[13:0], 14'h0} | 28'h4, i[0], 32'h1000 * i, i[3:0], i % 5, (i % 7) == 3, 0);
    repeat (3) @(negedge clk);
    chk(m_stall == 0, "R2 final idle", m_stall, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule